// File: doc/BRIEF.md
# Structural 4x4 Multiply-Accumulate Datapath

This block forms `y = (a * b + c) mod 256` for two 4-bit unsigned operands and an 8-bit unsigned addend. The arithmetic is built from gates and cells only. A grid of two-input AND gates produces the sixteen partial-product bits. A three-stage column-compression tree reduces those bits, together with the eight addend bits, to two rows. A short ripple adder then resolves the two rows into the final sum. The tree uses full-adder and half-adder cells, and a half adder appears only where a column height calls for one.

The addend does not pass through a separate adder. Each addend bit goes straight into the tree as one more bit in the column of its weight. This makes the whole operation a single compression problem of 24 input bits down to 8 output bits.

By default a registered output stage captures the result one clock after a valid input and raises a valid flag with it. A parameter removes the register and leaves the path purely combinational.

Top module: `dmac4`

## Requirements
- R1: For every combination of 4-bit `a`, 4-bit `b` and 8-bit `c`, the delivered result equals `(a*b + c) mod 256`, with all values unsigned.
- R2: Any carry beyond bit 7 is dropped. For example, a=15, b=15, c=255 gives 224, and a=1, b=1, c=255 gives 0.
- R3: Each partial-product bit is the AND of one bit of `a` and one bit of `b`. When `a` is 0 or `b` is 0, the result equals `c`.
- R4: The addend bits enter the compression tree in the columns of their own weight. When `c` is 0, the result is the plain product, for example 15*15 = 225.
- R5: With the output register present, `out_valid` is high in the cycle after an input with `in_valid` high, and `y` carries that input's result.
- R6: After a cycle with `in_valid` low, `out_valid` is low and `y` keeps its previous value, whatever `a`, `b` and `c` were.
- R7: While `rst_n` is low, `out_valid` is 0 and `y` is 0.
- R8: Inputs marked valid on consecutive cycles produce results on consecutive cycles, in the same order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks `a`, `b`, `c` as a valid operation |
| a | input | 4 | Unsigned multiplicand |
| b | input | 4 | Unsigned multiplier |
| c | input | 8 | Unsigned accumulator addend |
| out_valid | output | 1 | Result on `y` is new this cycle |
| y | output | 8 | Result, (a*b+c) mod 256 |

## Verification
Two things can happen in the same cycle: the register captures a new operation while it is still presenting the previous result. The bench provokes this by sweeping all 65,536 input combinations with `in_valid` held high every cycle. It also inserts idle gaps with random values on the inputs, and the directed carry-wrap cases run back to back. A queue records each expected result when its input is driven. Every cycle with `out_valid` high must pop the oldest entry and match it. Every cycle with `out_valid` low must show `y` unchanged from the previous cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MAC_OPW  = 4;                    // operand width
  localparam int MAC_ACCW = 8;                    // addend and result width
  localparam int MAC_PPN  = MAC_OPW * MAC_OPW;    // partial-product count

  typedef logic [MAC_OPW-1:0]  opnd_t;
  typedef logic [MAC_ACCW-1:0] acc_t;

  // Arithmetic reference: product plus addend, wrapped to the result width.
  function automatic acc_t mac_ref(opnd_t a, opnd_t b, acc_t c);
    logic [2*MAC_ACCW-1:0] wide;
    wide = 16'(a) * 16'(b) + 16'(c);
    return wide[MAC_ACCW-1:0];
  endfunction

  // Cell equations shared by the adder cells.
  function automatic logic bit_sum3(logic x, logic y, logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic bit_maj3(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/mac_fa.sv
module mac_fa import mac_pkg::*; (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = bit_sum3(a, b, ci);
  assign co = bit_maj3(a, b, ci);
endmodule

// File: rtl/mac_ha.sv
module mac_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/mac_ppgen.sv
// AND-gate grid: pp[i][j] = a[i] & b[j], weight 2^(i+j).
module mac_ppgen import mac_pkg::*; #(
  parameter int W = MAC_OPW
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  output logic [W-1:0][W-1:0] pp
);
  for (genvar i = 0; i < W; i++) begin : g_row
    for (genvar j = 0; j < W; j++) begin : g_col
      assign pp[i][j] = a[i] & b[j];
    end
  end
endmodule

// File: rtl/mac_dadda.sv
// Three-stage column compression of 16 product bits plus 8 addend bits
// down to two rows. Column height targets per stage: 4, 3, 2.
// Carries that would land at weight 2^8 never arise in this schedule.
module mac_dadda import mac_pkg::*; (
  input  logic [MAC_OPW-1:0][MAC_OPW-1:0] pp,
  input  logic [MAC_ACCW-1:0]             c,
  output logic [MAC_ACCW-1:0]             row_x,
  output logic [MAC_ACCW-1:0]             row_z
);
  // Stage 1 (max height 5 -> 4): columns 3 and 4.
  logic s1_3, k1_3, s1_4, k1_4;
  mac_ha u_s1_c3 (.a(pp[3][0]), .b(pp[2][1]), .s(s1_3), .co(k1_3));
  mac_ha u_s1_c4 (.a(pp[3][1]), .b(pp[2][2]), .s(s1_4), .co(k1_4));

  // Stage 2 (height 4 -> 3): columns 2..5.
  logic s2_2, k2_2, s2_3, k2_3, s2_4, k2_4, s2_5, k2_5;
  mac_ha u_s2_c2 (.a(pp[2][0]), .b(pp[1][1]), .s(s2_2), .co(k2_2));
  mac_fa u_s2_c3 (.a(s1_3), .b(pp[1][2]), .ci(pp[0][3]), .s(s2_3), .co(k2_3));
  mac_fa u_s2_c4 (.a(s1_4), .b(pp[1][3]), .ci(c[4]),     .s(s2_4), .co(k2_4));
  mac_fa u_s2_c5 (.a(pp[3][2]), .b(pp[2][3]), .ci(c[5]), .s(s2_5), .co(k2_5));

  // Stage 3 (height 3 -> 2): columns 1..6.
  logic s3_1, k3_1, s3_2, k3_2, s3_3, k3_3, s3_4, k3_4, s3_5, k3_5, s3_6, k3_6;
  mac_ha u_s3_c1 (.a(pp[1][0]), .b(pp[0][1]), .s(s3_1), .co(k3_1));
  mac_fa u_s3_c2 (.a(s2_2), .b(pp[0][2]), .ci(c[2]), .s(s3_2), .co(k3_2));
  mac_fa u_s3_c3 (.a(s2_3), .b(c[3]),     .ci(k2_2), .s(s3_3), .co(k3_3));
  mac_fa u_s3_c4 (.a(s2_4), .b(k1_3),     .ci(k2_3), .s(s3_4), .co(k3_4));
  mac_fa u_s3_c5 (.a(s2_5), .b(k1_4),     .ci(k2_4), .s(s3_5), .co(k3_5));
  mac_fa u_s3_c6 (.a(pp[3][3]), .b(c[6]), .ci(k2_5), .s(s3_6), .co(k3_6));

  // Two surviving rows, one bit per column.
  assign row_x = {c[7], s3_6, s3_5, s3_4, s3_3, s3_2, s3_1, pp[0][0]};
  assign row_z = {k3_6, k3_5, k3_4, k3_3, k3_2, k3_1, c[1], c[0]};
endmodule

// File: rtl/mac_cpa.sv
// Ripple carry resolution of the two rows; carry past the top bit is dropped.
module mac_cpa #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] z,
  output logic [W-1:0] s
);
  localparam int NR = W - 1;
  logic [NR-1:0] r;

  mac_ha u_b0 (.a(x[0]), .b(z[0]), .s(s[0]), .co(r[0]));
  for (genvar i = 1; i < NR; i++) begin : g_fa
    mac_fa u_fa (.a(x[i]), .b(z[i]), .ci(r[i-1]), .s(s[i]), .co(r[i]));
  end
  assign s[W-1] = x[W-1] ^ z[W-1] ^ r[NR-1];
endmodule

// File: rtl/dmac4.sv
module dmac4 import mac_pkg::*; #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [MAC_OPW-1:0]  a,
  input  logic [MAC_OPW-1:0]  b,
  input  logic [MAC_ACCW-1:0] c,
  output logic                out_valid,
  output logic [MAC_ACCW-1:0] y
);
  // Named internal nets, observed by the bound checker.
  logic [MAC_OPW-1:0][MAC_OPW-1:0] pp;
  logic [MAC_ACCW-1:0]             row_x;
  logic [MAC_ACCW-1:0]             row_z;
  logic [MAC_ACCW-1:0]             sum_comb;

  mac_ppgen #(.W(MAC_OPW)) u_pp (.a(a), .b(b), .pp(pp));
  mac_dadda u_tree (.pp(pp), .c(c), .row_x(row_x), .row_z(row_z));
  mac_cpa #(.W(MAC_ACCW)) u_cpa (.x(row_x), .z(row_z), .s(sum_comb));

  if (REG_OUT) begin : g_reg
    logic [MAC_ACCW-1:0] y_q;
    logic                v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= in_valid;
        if (in_valid) y_q <= sum_comb;
      end
    end
    assign y         = y_q;
    assign out_valid = v_q;
  end else begin : g_comb
    assign y         = sum_comb;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/dmac4_chk.sv
// Checker for the default registered configuration of dmac4.
module dmac4_chk import mac_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [MAC_OPW-1:0]  a,
  input logic [MAC_OPW-1:0]  b,
  input logic [MAC_ACCW-1:0] c,
  input logic                out_valid,
  input logic [MAC_ACCW-1:0] y,
  input logic [MAC_ACCW-1:0] sum_comb,
  input logic [MAC_ACCW-1:0] row_x,
  input logic [MAC_ACCW-1:0] row_z
);
  // R1: carry resolver output matches the arithmetic reference.
  a_r1_sum_matches_ref: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (sum_comb == mac_ref(a, b, c)));

  // R1/R2: the two tree rows add up to the wrapped reference.
  a_r2_rows_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (MAC_ACCW'(row_x + row_z) == mac_ref(a, b, c)));

  // R5: one-cycle latency, result follows its input.
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && (y == $past(mac_ref(a, b, c)))));

  // R6: idle input leaves the output held and not valid.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(y)));
endmodule

bind dmac4 dmac4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
  .out_valid(out_valid), .y(y), .sum_comb(sum_comb),
  .row_x(row_x), .row_z(row_z)
);

// File: tb/dmac4_tb.sv
module dmac4_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] a = '0;
  logic [3:0] b = '0;
  logic [7:0] c = '0;
  logic       out_valid;
  logic [7:0] y;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] last_y = '0;

  always #4 clk = ~clk;  // 125 MHz

  dmac4 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a(a), .b(b), .c(c), .out_valid(out_valid), .y(y)
  );

  // Shift-and-add model, wrapped to 8 bits.
  function automatic logic [7:0] bench_ref(logic [3:0] ma, logic [3:0] mb, logic [7:0] mc);
    logic [15:0] acc;
    acc = {8'd0, mc};
    for (int j = 0; j < 4; j++)
      if (mb[j]) acc = acc + ({12'd0, ma} << j);
    return acc[7:0];
  endfunction

  task automatic check(string req, logic cond, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic drive(logic [3:0] da, logic [3:0] db, logic [7:0] dc, string tag);
    @(negedge clk);
    a = da; b = db; c = dc; in_valid = 1'b1;
    exp_q.push_back(bench_ref(da, db, dc));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a = 4'($urandom); b = 4'($urandom); c = 8'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard on each valid result, checks hold otherwise.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected out_valid", 1'b0, 1, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, y == e, int'(y), int'(e));
        end
      end else begin
        check("R6 hold while idle", y == last_y, int'(y), int'(last_y));
      end
      last_y = y;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R7: reset state, with inputs driven as valid
    in_valid = 1'b1; a = 4'hF; b = 4'hF; c = 8'hFF;
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R7 reset y", y == 8'd0, int'(y), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // Directed corners, back to back (R8)
    drive(4'd15, 4'd15, 8'd255, "R2 wrap 15*15+255");
    drive(4'd1,  4'd1,  8'd255, "R2 wrap to zero");
    drive(4'd0,  4'd13, 8'd77,  "R3 a zero");
    drive(4'd9,  4'd0,  8'd200, "R3 b zero");
    drive(4'd15, 4'd15, 8'd0,   "R4 plain product");
    drive(4'd7,  4'd5,  8'd0,   "R4 plain product 35");
    drive(4'd3,  4'd11, 8'd100, "R8 consecutive");
    drive(4'd12, 4'd6,  8'd190, "R8 consecutive wrap");
    idle(3);
    drive(4'd5,  4'd5,  8'd1,   "R5 single after gap");
    idle(2);

    // R1: exhaustive sweep, gaps of random garbage every 4096 (R6)
    for (int i = 0; i < 65536; i++) begin
      drive(i[3:0], i[7:4], i[15:8], "R1 sweep");
      if ((i % 4096) == 4095) idle(3);
    end
    idle(4);
    check("R5 all results delivered", exp_q.size() == 0, exp_q.size(), 0);
    finish_run();
  end
endmodule